// File: doc/BRIEF.md
# Receive Buffer Status Update Logic

This block maintains a single dedicated receive message buffer. A frame decoder in front of it hands over one frame at a time: a one-cycle strobe, the header fields (frame identifier, cycle count, payload length), a null-frame marker and a stream of payload words. The block saves the header into registers and writes the payload words into a small internal RAM, one word per clock. It also keeps four status bits for the buffer: new data, status changed, message lost and the null-frame indication.

A null frame has no usable payload. For a null frame the block refreshes the header and raises the status-changed flag, but it leaves the stored payload as it was. A frame stored while the host still has unread data or an unread status change raises the message-lost flag. The host reads the header, the flags and the payload through plain ports. A one-cycle acknowledge clears the three event flags.

Top module: `rxbuf_status_upd`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it is released, nd_o, sc_o, ml_o, nfi_o and busy_o are 0.
- R2: A store of a non-null frame (frm_valid_i high while busy_o is low, frm_null_i low) loads frm_id_i, frm_cyc_i and frm_len_i into hdr_id_o, hdr_cyc_o and hdr_len_o, and sets nfi_o, nd_o and sc_o to 1. The new values are visible from the cycle after the strobe.
- R3: For a non-null store, the value on pld_data_i in the k-th cycle after the strobe cycle (k = 0 is the strobe cycle) is written to payload word k, for k below frm_len_i. busy_o is high for frm_len_i-1 cycles starting the cycle after the strobe. Words at index frm_len_i and above keep their old contents, and a length of 0 writes no word.
- R4: A null-frame store (frm_null_i high) writes no payload word, so every payload word keeps its previous value.
- R5: A null-frame store loads the header outputs from the frame, the same as R2, and clears nfi_o to 0.
- R6: A null-frame store sets sc_o and leaves nd_o at its previous value.
- R7: If nd_o or sc_o is 1 in the cycle of a store of either kind, ml_o is 1 after the store.
- R8: An ack_i pulse with no store in the same cycle clears nd_o, sc_o and ml_o in the next cycle. nfi_o and the header outputs are not changed.
- R9: When a store and ack_i happen in the same cycle, the store wins. The flags the store sets (sc_o always, nd_o for a non-null frame) are 1 afterwards. ml_o is set when nd_o or sc_o was 1 before that cycle.
- R10: frm_valid_i while busy_o is high is ignored. The header, the flags and the payload in progress are not changed by it.
- R11: rd_data_o gives the payload word addressed by rd_addr_i, one clock cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frm_valid_i | input | 1 | One-cycle frame strobe |
| frm_null_i | input | 1 | Frame is a null frame |
| frm_id_i | input | ID_W | Frame identifier |
| frm_cyc_i | input | CYC_W | Receive cycle count |
| frm_len_i | input | LEN_W | Payload length in words, at most MAX_WORDS |
| pld_data_i | input | WORD_W | Payload word stream, word 0 in the strobe cycle |
| ack_i | input | 1 | Host read acknowledge |
| rd_addr_i | input | ADDR_W | Host payload read address |
| rd_data_o | output | WORD_W | Payload read data, one cycle latency |
| hdr_id_o | output | ID_W | Stored frame identifier |
| hdr_cyc_o | output | CYC_W | Stored cycle count |
| hdr_len_o | output | LEN_W | Stored payload length |
| nfi_o | output | 1 | Null-frame indication (1 = frame carried data) |
| nd_o | output | 1 | New data flag |
| sc_o | output | 1 | Status changed flag |
| ml_o | output | 1 | Message lost flag |
| busy_o | output | 1 | Payload write in progress |

## Verification
The bench first fills the whole buffer with a full-length frame. It then sends a shorter frame. A sequencer that counted past the length would overwrite the tail words, and one that was off by one would drop the last word. Null frames are sent after an acknowledge and again without one. A design that wrote null payloads would show changed words, and one that set new-data for a null frame would show nd_o high. A frame stored on top of unread data, a store in the same cycle as an acknowledge, and a second strobe in the middle of a payload burst check the other cases. A wrong design would lose ml_o, let the acknowledge win, or let the second strobe replace the header in the middle of the burst.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;
  typedef struct packed {
    logic nfi;
    logic ml;
    logic sc;
    logic nd;
  } rxbuf_flags_t;
endpackage

// File: rtl/rxbuf_wr_seq.sv
module rxbuf_wr_seq #(
  parameter int ADDR_W = 3,
  parameter int LEN_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frm_valid_i,
  input  logic              frm_null_i,
  input  logic [LEN_W-1:0]  frm_len_i,
  output logic              store_o,
  output logic              busy_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o
);
  logic              busy_q;
  logic [ADDR_W-1:0] idx_q;
  logic [LEN_W-1:0]  len_q;
  logic              last_w;

  assign store_o = frm_valid_i & ~busy_q;
  assign busy_o  = busy_q;
  assign last_w  = (idx_q == ADDR_W'(len_q - 1'b1));
  assign we_o    = busy_q | (store_o & ~frm_null_i & (frm_len_i != '0));
  assign waddr_o = busy_q ? idx_q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      len_q  <= '0;
    end else if (busy_q) begin
      if (last_w) busy_q <= 1'b0;
      else        idx_q  <= idx_q + 1'b1;
    end else if (store_o && !frm_null_i && frm_len_i > LEN_W'(1)) begin
      busy_q <= 1'b1;
      idx_q  <= ADDR_W'(1);
      len_q  <= frm_len_i;
    end
  end

  assert_idx_in_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (LEN_W'(idx_q) < len_q));
  assert_burst_end_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_q) |-> ($past(idx_q) == ADDR_W'($past(len_q) - 1'b1)));
  assert_null_no_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_o && frm_null_i) |=> !busy_q);
  assert_busy_blocks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !store_o);
endmodule

// File: rtl/rxbuf_ram.sv
module rxbuf_ram #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 8,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/rxbuf_flags.sv
module rxbuf_flags
  import rxbuf_pkg::*;
#(
  parameter int ID_W  = 11,
  parameter int CYC_W = 6,
  parameter int LEN_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              store_i,
  input  logic              null_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [CYC_W-1:0]  cyc_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              ack_i,
  output logic [ID_W-1:0]   hdr_id_o,
  output logic [CYC_W-1:0]  hdr_cyc_o,
  output logic [LEN_W-1:0]  hdr_len_o,
  output rxbuf_flags_t      flags_o
);
  rxbuf_flags_t flg_q;
  logic         pending_w;

  assign pending_w = flg_q.nd | flg_q.sc;
  assign flags_o   = flg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flg_q     <= '0;
      hdr_id_o  <= '0;
      hdr_cyc_o <= '0;
      hdr_len_o <= '0;
    end else begin
      if (ack_i) begin
        flg_q.nd <= 1'b0;
        flg_q.sc <= 1'b0;
        flg_q.ml <= 1'b0;
      end
      // store overrides ack
      if (store_i) begin
        hdr_id_o  <= id_i;
        hdr_cyc_o <= cyc_i;
        hdr_len_o <= len_i;
        flg_q.sc  <= 1'b1;
        flg_q.ml  <= (flg_q.ml & ~ack_i) | pending_w;
        flg_q.nfi <= ~null_i;
        if (!null_i) flg_q.nd <= 1'b1;
      end
    end
  end

  assert_data_store_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_i && !null_i) |=> (flg_q.nd && flg_q.sc && flg_q.nfi));
  assert_null_nfi_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_i && null_i) |=> (!flg_q.nfi && flg_q.sc));
  assert_null_keeps_nd_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_i && null_i && !ack_i) |=> (flg_q.nd == $past(flg_q.nd)));
  assert_lost_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (store_i && pending_w) |=> flg_q.ml);
  assert_ack_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !store_i) |=> (!flg_q.nd && !flg_q.sc && !flg_q.ml && $stable(flg_q.nfi)));
endmodule

// File: rtl/rxbuf_status_upd.sv
module rxbuf_status_upd
  import rxbuf_pkg::*;
#(
  parameter int ID_W      = 11,
  parameter int CYC_W     = 6,
  parameter int WORD_W    = 32,
  parameter int MAX_WORDS = 8,
  localparam int ADDR_W   = $clog2(MAX_WORDS),
  localparam int LEN_W    = $clog2(MAX_WORDS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frm_valid_i,
  input  logic              frm_null_i,
  input  logic [ID_W-1:0]   frm_id_i,
  input  logic [CYC_W-1:0]  frm_cyc_i,
  input  logic [LEN_W-1:0]  frm_len_i,
  input  logic [WORD_W-1:0] pld_data_i,
  input  logic              ack_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [ID_W-1:0]   hdr_id_o,
  output logic [CYC_W-1:0]  hdr_cyc_o,
  output logic [LEN_W-1:0]  hdr_len_o,
  output logic              nfi_o,
  output logic              nd_o,
  output logic              sc_o,
  output logic              ml_o,
  output logic              busy_o
);
  logic              store_w;
  logic              we_w;
  logic [ADDR_W-1:0] waddr_w;
  rxbuf_flags_t      flags_w;

  rxbuf_wr_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .frm_valid_i (frm_valid_i),
    .frm_null_i  (frm_null_i),
    .frm_len_i   (frm_len_i),
    .store_o     (store_w),
    .busy_o      (busy_o),
    .we_o        (we_w),
    .waddr_o     (waddr_w)
  );

  rxbuf_ram #(.WORD_W(WORD_W), .DEPTH(MAX_WORDS)) u_ram (
    .clk_i   (clk_i),
    .we_i    (we_w),
    .waddr_i (waddr_w),
    .wdata_i (pld_data_i),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );

  rxbuf_flags #(.ID_W(ID_W), .CYC_W(CYC_W), .LEN_W(LEN_W)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .store_i   (store_w),
    .null_i    (frm_null_i),
    .id_i      (frm_id_i),
    .cyc_i     (frm_cyc_i),
    .len_i     (frm_len_i),
    .ack_i     (ack_i),
    .hdr_id_o  (hdr_id_o),
    .hdr_cyc_o (hdr_cyc_o),
    .hdr_len_o (hdr_len_o),
    .flags_o   (flags_w)
  );

  assign nfi_o = flags_w.nfi;
  assign nd_o  = flags_w.nd;
  assign sc_o  = flags_w.sc;
  assign ml_o  = flags_w.ml;

  assert_len_legal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_valid_i |-> (int'(frm_len_i) <= MAX_WORDS));
endmodule

// File: tb/rxbuf_status_upd_tb_top.sv
module rxbuf_status_upd_tb_top;
  localparam int ID_W = 11, CYC_W = 6, WORD_W = 32, MAX_WORDS = 8;
  localparam int ADDR_W = $clog2(MAX_WORDS), LEN_W = $clog2(MAX_WORDS + 1);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic frm_valid_i = 0, frm_null_i = 0, ack_i = 0;
  logic [ID_W-1:0] frm_id_i = '0;
  logic [CYC_W-1:0] frm_cyc_i = '0;
  logic [LEN_W-1:0] frm_len_i = '0;
  logic [WORD_W-1:0] pld_data_i = '0;
  logic [ADDR_W-1:0] rd_addr_i = '0;
  logic [WORD_W-1:0] rd_data_o;
  logic [ID_W-1:0] hdr_id_o;
  logic [CYC_W-1:0] hdr_cyc_o;
  logic [LEN_W-1:0] hdr_len_o;
  logic nfi_o, nd_o, sc_o, ml_o, busy_o;

  int n_chk = 0, n_fail = 0, cyc_cnt = 0;
  logic [WORD_W-1:0] exp_mem [MAX_WORDS];
  logic e_nd = 0, e_sc = 0, e_ml = 0, e_nfi = 0;
  logic [ID_W-1:0] e_id = '0;
  logic [CYC_W-1:0] e_cyc = '0;
  logic [LEN_W-1:0] e_len = '0;

  always #5 clk = ~clk;

  rxbuf_status_upd dut_i (.clk_i(clk), .*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk(nd_o == e_nd, {req, " nd"}, nd_o, e_nd);
    chk(sc_o == e_sc, {req, " sc"}, sc_o, e_sc);
    chk(ml_o == e_ml, {req, " ml"}, ml_o, e_ml);
    chk(nfi_o == e_nfi, {req, " nfi"}, nfi_o, e_nfi);
    chk(hdr_id_o == e_id, {req, " id"}, hdr_id_o, e_id);
    chk(hdr_cyc_o == e_cyc, {req, " cyc"}, hdr_cyc_o, e_cyc);
    chk(hdr_len_o == e_len, {req, " len"}, hdr_len_o, e_len);
  endtask

  task automatic chk_mem(input string req);
    for (int a = 0; a < MAX_WORDS; a++) begin
      rd_addr_i = ADDR_W'(a);
      @(negedge clk);
      chk(rd_data_o == exp_mem[a], req, rd_data_o, exp_mem[a]);
    end
  endtask

  // strobe at k=0, one payload word per cycle; glitch re-strobes at k=1
  task automatic send(input int id, input int cy, input int len, input bit nul,
                      input bit ack, input bit glitch, input string req);
    int n = (len > 1) ? len : 1;
    if (glitch && n < 2) n = 2;
    for (int k = 0; k < n; k++) begin
      frm_valid_i = (k == 0) || (glitch && k == 1);
      frm_id_i    = ID_W'((k == 0) ? id : id ^ 'h55);
      frm_cyc_i   = CYC_W'(cy);
      frm_len_i   = LEN_W'(len);
      frm_null_i  = (k == 0) ? nul : 1'b1;
      ack_i       = (k == 0) && ack;
      pld_data_i  = {16'(id), 16'(k)};
      if (k == 0) begin
        logic pre = e_nd | e_sc;
        if (ack) begin e_nd = 0; e_sc = 0; e_ml = 0; end
        e_ml = e_ml | pre; e_sc = 1;
        if (!nul) begin e_nd = 1; e_nfi = 1; end else e_nfi = 0;
        e_id = ID_W'(id); e_cyc = CYC_W'(cy); e_len = LEN_W'(len);
      end
      if (!nul && k < len) exp_mem[k] = {16'(id), 16'(k)};
      @(negedge clk);
      if (k == 0) chk(busy_o == (!nul && len > 1), "R3 busy", busy_o, (!nul && len > 1));
    end
    frm_valid_i = 0; ack_i = 0; frm_null_i = 0;
    @(negedge clk);
    chk(busy_o == 1'b0, "R3 busy end", busy_o, 0);
    chk_state(req);
  endtask

  task automatic do_ack(input string req);
    ack_i = 1;
    @(negedge clk);
    ack_i = 0;
    e_nd = 0; e_sc = 0; e_ml = 0;
    chk_state(req);
  endtask

  task automatic t_reset;
    chk(nd_o == 0 && sc_o == 0 && ml_o == 0 && nfi_o == 0 && busy_o == 0,
        "R1 reset", {nd_o, sc_o, ml_o, nfi_o, busy_o}, 0);
    rst_ni = 1;
    @(negedge clk);
    chk(nd_o == 0 && sc_o == 0 && ml_o == 0 && nfi_o == 0 && busy_o == 0,
        "R1 after release", {nd_o, sc_o, ml_o, nfi_o, busy_o}, 0);
  endtask

  task automatic t_full_frame;
    send('h101, 3, MAX_WORDS, 0, 0, 0, "R2 full frame");
    chk_mem("R3 R11 full payload");
  endtask

  task automatic t_short_frame;
    do_ack("R8 ack");
    send('h102, 4, 3, 0, 0, 0, "R2 short frame");
    chk_mem("R3 tail untouched");
  endtask

  task automatic t_null;
    do_ack("R8 ack before null");
    send('h203, 9, 5, 1, 0, 0, "R5 R6 null frame");
    chk_mem("R4 null payload untouched");
  endtask

  task automatic t_lost;
    send('h204, 10, 2, 1, 0, 0, "R7 null over pending sc");
    chk(ml_o == 1, "R7 ml", ml_o, 1);
    send('h305, 11, 2, 0, 0, 0, "R7 data over pending");
    chk_mem("R3 after lost");
    do_ack("R8 ack clears ml");
  endtask

  task automatic t_ack_collide;
    send('h306, 12, 1, 0, 0, 0, "R2 len 1");
    send('h307, 13, 4, 0, 1, 0, "R9 store with ack");
    chk(nd_o == 1 && sc_o == 1, "R9 flags set", {nd_o, sc_o}, 3);
    chk_mem("R9 payload");
  endtask

  task automatic t_busy_strobe;
    do_ack("R8 ack");
    send('h408, 14, 5, 0, 0, 1, "R10 strobe while busy");
    chk_mem("R10 payload intact");
  endtask

  task automatic t_len_zero;
    send('h509, 15, 0, 0, 0, 0, "R3 len zero");
    chk_mem("R3 len zero no write");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_full_frame();
    t_short_frame();
    t_null();
    t_lost();
    t_ack_collide();
    t_busy_strobe();
    t_len_zero();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc_cnt, 20000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule